// File: doc/BRIEF.md
# Tiled Surface Address Generator

This block turns a pixel coordinate on a two-dimensional surface into a byte offset inside a memory layout built from 64 KiB tiles. Within each tile the bytes follow a fixed swizzle. Each request carries the pixel size in bits, the x and y coordinate and the surface width in pixels. One cycle later the block returns the 32-bit byte offset of that pixel, counted from the start of the surface.

The pixel size is first reduced to a size class. The class sets the tile shape in elements and the swizzle row. The surface width is rounded up to a whole number of tiles, and tiles are numbered row by row. The low 16 bits of the result are assembled one bit at a time, each bit taken from a chosen bit of x or y. The block accepts one request per cycle through a valid/ready handshake. It holds its result while the consumer stalls.

Top module: `tag_top`

## Requirements
- R1: The element byte count is bpp/8, taken from bpp_i[7:3]. The size class is the number of halvings, rounding up at each step, that bring this count down to 1. Byte counts 0 and 1 give class 0, 2 gives class 1, 3 and 4 give class 2, 5 to 8 give class 3, and 9 to 16 give class 4.
- R2: err_o is 1 exactly when bpp_i[2:0] is not zero or bpp_i is greater than 128. When err_o is 1, offset_o carries no defined value.
- R3: Tile width and height in elements, by class 0 to 4, are (256,256), (256,128), (128,128), (128,64) and (64,64).
- R4: The tiles per row equal width_i divided by the tile width, rounded up. The tile index is (y / tile height) × tiles per row + (x / tile width). offset_o is (tile index × 65536) + in-tile offset, kept to its low 32 bits.
- R5: Before the in-tile offset is assembled, x is shifted left by the size class. y is used unshifted.
- R6: In-tile offset bits 0 and 1 are always 0. Bits 2, 3, 7, 9, 11, 13 and 15 take their value from the shifted x. Bits 4, 5, 6, 8, 10, 12 and 14 take their value from y.
- R7: Each in-tile bit has a selector number n that depends on the class. An x-sourced bit takes bit n+2 of the shifted x, and a y-sourced bit takes bit n of y. The values of n for bits 0 to 15 are:
  - class 0: 0,1,2,3,0,1,2,3,4,4,5,5,6,6,7,7
  - class 1: 0,0,1,2,0,1,2,3,3,4,4,5,5,6,6,7
  - class 2: 0,0,0,1,0,1,2,2,3,3,4,4,5,5,6,6
  - class 3: 0,0,0,0,0,1,1,2,2,3,3,4,4,5,5,6
  - class 4: 0,0,0,0,0,1,0,1,2,2,3,3,4,4,5,5
- R8: A request is taken on a clock edge where in_valid_i and in_ready_o are both 1. Its result appears with out_valid_o at 1 after that same edge, so the latency is one cycle. in_ready_o is 1 whenever the output register is empty or out_ready_i is 1, which allows one request per cycle.
- R9: While out_valid_o is 1 and out_ready_i is 0, out_valid_o, offset_o and err_o keep their values.
- R10: After rst_ni is asserted, out_valid_o is 0 and in_ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request valid |
| in_ready_o | output | 1 | Request can be taken |
| bpp_i | input | 8 | Bits per pixel |
| x_i | input | 16 | Pixel column |
| y_i | input | 16 | Pixel row |
| width_i | input | 16 | Surface width in pixels |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Consumer takes the result |
| offset_o | output | 32 | Byte offset of the pixel |
| err_o | output | 1 | Unsupported pixel size |

## Verification
The assertions check the handshake on every cycle: the one-cycle latency, the held result under backpressure, the error flag against the pixel size that was accepted, and the zero offset for the origin pixel. The bench scenarios cover the mapping itself. They compare every result with an independent model of the class table, the tile shapes, the pitch rounding and the per-bit swizzle. They use hand-computed offsets for 4-byte pixels, several element sizes, coordinates that cross tile edges, and random stalls on the output.

// File: rtl/tag_pkg.sv
package tag_pkg;
  localparam int TILE_LOG2  = 16;
  localparam int BLK_LOG2   = 8;
  localparam int AMP_W      = (TILE_LOG2 - BLK_LOG2) / 2;
  localparam int AMP_H      = TILE_LOG2 - BLK_LOG2 - AMP_W;
  localparam int BASE0_LOG2 = 4;   // class 0 base block is 16x16 elements
  localparam int N_CLS      = 5;
  localparam int SX_W       = 10;  // shifted-x bits reachable by the swizzle
  localparam int SY_W       = 8;   // y bits reachable by the swizzle

  typedef enum logic [1:0] {CH_NONE, CH_X, CH_Y} chan_e;

  function automatic chan_e chan_of(input int b);
    case (b)
      0, 1:                     return CH_NONE;
      2, 3, 7, 9, 11, 13, 15:   return CH_X;
      default:                  return CH_Y;
    endcase
  endfunction

  // selector number n per in-tile bit, nibble b holds bit b
  function automatic logic [3:0] sel_of(input logic [2:0] cls, input int b);
    logic [63:0] row;
    case (cls)
      3'd0:    row = 64'h7766_5544_3210_3210;
      3'd1:    row = 64'h7665_5443_3210_2100;
      3'd2:    row = 64'h6655_4433_2210_1000;
      3'd3:    row = 64'h6554_4332_2110_0000;
      default: row = 64'h5544_3322_1010_0000;
    endcase
    return row[4*b +: 4];
  endfunction
endpackage

// File: rtl/tag_size_class.sv
module tag_size_class
  import tag_pkg::*;
#(
  parameter int BPP_W   = 8,
  parameter int MAX_BPP = 128
) (
  input  logic [BPP_W-1:0] bpp_i,
  output logic [2:0]       cls_o,
  output logic [3:0]       tw_log2_o,
  output logic [3:0]       th_log2_o,
  output logic             err_o
);
  localparam int EB_W = BPP_W - 3;

  logic [EB_W-1:0] eb, eb_m1;
  logic [2:0]      cls_raw;

  assign eb    = bpp_i[BPP_W-1:3];
  assign eb_m1 = eb - EB_W'(1);

  // halvings with round-up equal the bit length of (bytes - 1)
  always_comb begin
    cls_raw = '0;
    if (eb > EB_W'(1)) begin
      for (int i = 0; i < EB_W; i++)
        if (eb_m1[i]) cls_raw = 3'(i + 1);
    end
  end

  assign cls_o = (cls_raw > 3'(N_CLS - 1)) ? 3'(N_CLS - 1) : cls_raw;

  // width halves on even class steps, height on odd ones
  assign tw_log2_o = 4'(BASE0_LOG2 + AMP_W) - 4'(cls_o >> 1);
  assign th_log2_o = 4'(BASE0_LOG2 + AMP_H) - 4'((cls_o + 3'd1) >> 1);

  assign err_o = (|bpp_i[2:0]) || (bpp_i > BPP_W'(MAX_BPP));
endmodule

// File: rtl/tag_swizzle.sv
module tag_swizzle
  import tag_pkg::*;
#(
  parameter int OFF_BITS = TILE_LOG2
) (
  input  logic [2:0]          cls_i,
  input  logic [SX_W-1:0]     x_lo_i,
  input  logic [SY_W-1:0]     y_lo_i,
  output logic [OFF_BITS-1:0] off_o
);
  logic [SX_W-1:0] xs;
  assign xs = x_lo_i << cls_i;

  for (genvar b = 0; b < OFF_BITS; b++) begin : g_bit
    localparam chan_e CH = chan_of(b);
    if (CH == CH_X) begin : g_x
      logic [3:0] n;
      assign n        = sel_of(cls_i, b);
      assign off_o[b] = |(xs & (SX_W'(1) << (n + 4'd2)));
    end else if (CH == CH_Y) begin : g_y
      logic [3:0] n;
      assign n        = sel_of(cls_i, b);
      assign off_o[b] = |(y_lo_i & (SY_W'(1) << n));
    end else begin : g_none
      assign off_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/tag_tile_index.sv
module tag_tile_index #(
  parameter int COORD_W = 16,
  parameter int IDX_W   = 16
) (
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] y_i,
  input  logic [COORD_W-1:0] width_i,
  input  logic [3:0]         tw_log2_i,
  input  logic [3:0]         th_log2_i,
  output logic [IDX_W-1:0]   idx_o
);
  localparam int PW = COORD_W + 1;

  logic [PW-1:0]      w_round, pitch_tiles;
  logic [COORD_W-1:0] tile_x, tile_y;

  assign w_round     = {1'b0, width_i} + (PW'(1) << tw_log2_i) - PW'(1);
  assign pitch_tiles = w_round >> tw_log2_i;
  assign tile_x      = x_i >> tw_log2_i;
  assign tile_y      = y_i >> th_log2_i;

  assign idx_o = IDX_W'(tile_y) * IDX_W'(pitch_tiles) + IDX_W'(tile_x);
endmodule

// File: rtl/tag_top.sv
module tag_top
  import tag_pkg::*;
#(
  parameter int BPP_W   = 8,
  parameter int COORD_W = 16,
  parameter int OFF_W   = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [BPP_W-1:0]   bpp_i,
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] y_i,
  input  logic [COORD_W-1:0] width_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [OFF_W-1:0]   offset_o,
  output logic               err_o
);
  localparam int IDX_W = OFF_W - TILE_LOG2;

  logic [2:0]           cls;
  logic [3:0]           tw_log2, th_log2;
  logic                 bpp_err;
  logic [TILE_LOG2-1:0] in_tile;
  logic [IDX_W-1:0]     tile_idx;
  logic                 accept;

  tag_size_class #(.BPP_W(BPP_W)) u_size (
    .bpp_i     (bpp_i),
    .cls_o     (cls),
    .tw_log2_o (tw_log2),
    .th_log2_o (th_log2),
    .err_o     (bpp_err)
  );

  tag_swizzle #(.OFF_BITS(TILE_LOG2)) u_swz (
    .cls_i  (cls),
    .x_lo_i (x_i[SX_W-1:0]),
    .y_lo_i (y_i[SY_W-1:0]),
    .off_o  (in_tile)
  );

  tag_tile_index #(.COORD_W(COORD_W), .IDX_W(IDX_W)) u_idx (
    .x_i       (x_i),
    .y_i       (y_i),
    .width_i   (width_i),
    .tw_log2_i (tw_log2),
    .th_log2_i (th_log2),
    .idx_o     (tile_idx)
  );

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      offset_o    <= '0;
      err_o       <= 1'b0;
    end else begin
      if (accept) begin
        out_valid_o <= 1'b1;
        offset_o    <= {tile_idx, in_tile};
        err_o       <= bpp_err;
      end else if (out_ready_i) begin
        out_valid_o <= 1'b0;
      end
    end
  end

  p_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> out_valid_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(offset_o) && $stable(err_o)));

  p_err_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (err_o == (($past(bpp_i[2:0]) != 3'd0) || ($past(bpp_i) > BPP_W'(128)))));

  p_origin_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && x_i == '0 && y_i == '0 && !bpp_err) |=> (offset_o == '0));
endmodule

// File: tb/tag_top_bench.sv
module tag_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  bpp = 8'd32;
  logic [15:0] x = '0, y = '0, width = 16'd64;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] offset;
  logic        err;
  logic        bp_mode = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct packed {
    logic        chk_off;
    logic        err;
    logic [31:0] off;
    logic [7:0]  tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  tag_top u_tag_top (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .bpp_i(bpp), .x_i(x), .y_i(y), .width_i(width),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .offset_o(offset), .err_o(err)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // independent model: halving loops, one-hot selector rows, channel masks
  function automatic logic [32:0] model(input int b_pp, input int px, input int py, input int w);
    int eb, cls, bw, bh, tw, th, pt, idx, v, n;
    logic [127:0] row;
    logic [15:0]  xm, ym, intile;
    logic [31:0]  addr;
    logic         e;
    eb = b_pp / 8; cls = 0;
    while (eb > 1) begin cls++; eb = (eb + 1) >> 1; end
    e = (b_pp % 8 != 0) || (b_pp > 128);
    if (cls > 4) cls = 4;
    case (cls)
      0: begin bw = 16; bh = 16; end
      1: begin bw = 16; bh = 8;  end
      2: begin bw = 8;  bh = 8;  end
      3: begin bw = 8;  bh = 4;  end
      default: begin bw = 4; bh = 4; end
    endcase
    tw = bw << 4; th = bh << 4;
    pt = (w + tw - 1) / tw;
    idx = (py / th) * pt + px / tw;
    case (cls)
      0: row = 128'h8080_4040_2020_1010_0804_0201_0804_0201;
      1: row = 128'h8040_4020_2010_1008_0804_0201_0402_0100;
      2: row = 128'h4040_2020_1010_0808_0404_0201_0201_0000;
      3: row = 128'h4020_2010_1008_0804_0402_0201_0100_0000;
      default: row = 128'h2020_1010_0808_0404_0201_0201_0000_0000;
    endcase
    xm = 16'hAA8C; ym = 16'h5570; intile = '0;
    for (int b = 0; b < 16; b++) begin
      v = int'(row[8*b +: 8]); n = 0;
      while (v > 1) begin n++; v = (v + 1) >> 1; end
      if (xm[b]) intile[b] = 1'(((px << cls) >> (n + 2)) & 1);
      else if (ym[b]) intile[b] = 1'((py >> n) & 1);
    end
    addr = 32'(idx << 16) + 32'(intile);
    return {e, addr};
  endfunction

  // driver: called at a negedge, returns at a negedge with the request taken
  task automatic send(input int b_pp, input int px, input int py, input int w,
                      input bit use_lit, input logic [31:0] lit, input logic [7:0] tag);
    logic [32:0] m;
    exp_t it;
    in_valid = 1'b1; bpp = 8'(b_pp); x = 16'(px); y = 16'(py); width = 16'(w);
    while (!in_ready) @(negedge clk);
    m = model(b_pp, px, py, w);
    it.err = m[32];
    it.off = use_lit ? lit : m[31:0];
    it.chk_off = !m[32];
    it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    check(out_valid === 1'b1, "R8 latency", 64'(out_valid), 64'd1);
  endtask

  // consumer stalls while bp_mode is set
  always @(posedge clk) begin
    #2;
    out_ready = bp_mode ? 1'($urandom % 2) : 1'b1;
  end

  logic        was_stall = 1'b0;
  logic [31:0] prev_off;
  logic        prev_err;
  always @(negedge clk) begin
    if (rst_n) begin
      if (was_stall) begin
        check(out_valid === 1'b1 && offset === prev_off && err === prev_err, "R9 hold",
              64'({out_valid, err, offset}), 64'({1'b1, prev_err, prev_off}));
      end
      if (out_valid && out_ready) begin
        exp_t it;
        if (sb.size() == 0) begin
          check(1'b0, "R8 unexpected output", 64'(offset), 64'd0);
        end else begin
          it = sb.pop_front();
          // tags: 1=R1 class, 2=R2 error, 3=R3 tile dims, 4=R4 index, 5=R5/R6/R7 swizzle
          check(err === it.err, $sformatf("R2 err tag%0d", it.tag), 64'(err), 64'(it.err));
          if (it.chk_off)
            check(offset === it.off, $sformatf("R1/R3/R4/R5/R6/R7 offset tag%0d", it.tag),
                  64'(offset), 64'(it.off));
        end
      end
      was_stall = out_valid && !out_ready;
      prev_off = offset;
      prev_err = err;
    end
  end

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
  end

  initial begin
    int bpp_list[9] = '{8, 16, 24, 32, 40, 64, 72, 128, 0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && in_ready === 1'b1, "R10 reset state",
          64'({out_valid, in_ready}), 64'b01);

    // hand-computed 4-byte pixel offsets (class 2, 128x128 tiles)
    send(32, 1, 0, 100, 1, 32'h0000_0004, 8'd5);     // R7 bit2 from x
    send(32, 0, 1, 100, 1, 32'h0000_0010, 8'd5);     // R6 bit4 from y
    send(32, 0, 0, 100, 1, 32'h0000_0000, 8'd4);     // R4 origin
    send(32, 128, 0, 200, 1, 32'h0001_0000, 8'd3);   // R3 next tile across
    send(32, 0, 128, 200, 1, 32'h0002_0000, 8'd4);   // R4 pitch 2 tiles
    send(32, 0, 128, 129, 1, 32'h0002_0000, 8'd4);   // R4 width rounds up
    send(32, 0, 128, 128, 1, 32'h0001_0000, 8'd4);   // R4 exact multiple
    send(32, 2, 0, 100, 1, 32'h0000_0008, 8'd5);     // R5 x shifted by class
    // class per size, same coordinate
    foreach (bpp_list[i]) send(bpp_list[i], 37, 19, 300, 0, '0, 8'd1); // R1
    // errors
    send(12, 5, 5, 64, 0, '0, 8'd2);                 // R2 not multiple of 8
    send(136, 5, 5, 64, 0, '0, 8'd2);                // R2 above 128
    send(255, 5, 5, 64, 0, '0, 8'd2);                // R2
    // tile edges per class: R3
    foreach (bpp_list[i]) begin
      send(bpp_list[i], 63, 63, 1000, 0, '0, 8'd3);
      send(bpp_list[i], 64, 64, 1000, 0, '0, 8'd3);
      send(bpp_list[i], 255, 127, 1000, 0, '0, 8'd3);
      send(bpp_list[i], 256, 128, 1000, 0, '0, 8'd3);
    end
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    // random sweep under backpressure: R9, R5, R6, R7
    bp_mode = 1'b1;
    for (int k = 0; k < 400; k++) begin
      int bsel = int'($urandom % 9);
      send(bpp_list[bsel], int'($urandom % 4096), int'($urandom % 4096),
           int'($urandom % 4096) + 1, 0, '0, 8'd5);
    end
    in_valid = 1'b0;
    bp_mode = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R8 drains", 64'(out_valid), 64'd0);
    report();
  end
endmodule